// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block sits between an internal bus master and an external 16-bit DRAM. It turns one read or write request into a fixed DRAM access cycle. The cycle has four base states: a precharge state, a row state and two column states. The master raises `req_valid` with an address, a direction, a size and write data. The block decodes which of four DRAM-capable address areas the address falls in. It then drives that area's own row strobe and multiplexes the row and column address onto a 13-bit address bus. It also generates the upper and lower column strobes, the write enable and an optional read output enable. `req_ack` answers the master once the access is complete.

An external wait input can lengthen the cycle. Each area has its own wait-enable bit. That bit only decides whether wait states may be inserted; the four base states are always run. Every DRAM-side output is registered and changes on a clock edge, in step with the state it belongs to.

The data bus is split into an input, an output and an output-enable, so a pad ring can build the bidirectional pins outside the block.

Top module: `dram_cycle_seq`

## Requirements
- R1: An accepted request runs precharge, row, column-1 and column-2 states, one cycle each in that order. The first state is visible in the cycle after the edge that accepts the request. With no waits, `req_ack` is high in the fifth cycle after acceptance.
- R2: The address area is byte address bits [23:21]. Areas 2, 3, 4 and 5 drive row strobes `dram_ras_n[0..3]` respectively. An area is DRAM only when its `cfg_dram_map` bit (same index) is 1. Only the accessed area's strobe goes low. A request to any other area, or to an unmapped area, is ignored: it causes no strobe and no ack.
- R3: The row address is byte address bits [20:11], zero-extended to 13 bits. The column address is bits [10:1], zero-extended. The row address is on `dram_addr` during the precharge and row states. The column address is on it during the column and wait states.
- R4: The row strobe is high in the precharge state and low from the row state through column-2. Column strobes are low from column-1 through column-2, including wait states, and high otherwise.
- R5: Word accesses (`req_word`=1) and all reads assert both column strobes. A byte write to an even address asserts only `dram_ucas_n` (data bits 15:8). A byte write to an odd address asserts only `dram_lcas_n`.
- R6: For writes, `dram_we_n` is low and `dram_dq_oe` is high during the column and wait states, with `dram_dq_o` equal to the request's write data. For reads, `dram_we_n` stays high and the data bus is not driven.
- R7: During the column and wait states of a read, `dram_oe_n` is low only when `cfg_oe_en` is 1. It is high at all other times.
- R8: When the accessed area's `cfg_wait_en` bit is 1, `dram_wait` is sampled at the edge ending column-1 and at the edge ending each wait state. Each sample taken high adds one wait state between column-1 and column-2, and all strobes hold their values during it.
- R9: When the accessed area's `cfg_wait_en` bit is 0, no wait state is ever inserted, whatever `dram_wait` does.
- R10: `req_ack` is high for exactly one cycle, the one after column-2. In a read, `rd_data` in that cycle holds `dram_dq_i` as sampled at the edge ending column-2.
- R11: After a synchronous reset, all strobes, `dram_we_n` and `dram_oe_n` are high, and `dram_dq_oe` and `req_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data, already placed on its byte lane |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, valid with ack |
| cfg_dram_map | input | 4 | Per-area DRAM enable, bit i for area i+2 |
| cfg_wait_en | input | 4 | Per-area wait insertion enable |
| cfg_oe_en | input | 1 | Enables the read output enable |
| dram_addr | output | 13 | Multiplexed row/column address |
| dram_ras_n | output | 4 | Row strobes, active low, one per area |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Write data to pads |
| dram_dq_oe | output | 1 | Data pad drive enable |
| dram_dq_i | input | 16 | Read data from pads |
| dram_wait | input | 1 | Wait request |

## Verification
The bench sweeps every area and direction, both byte lanes, word size, zero to two wait samples, and both settings of the wait-enable and output-enable bits. It compares every DRAM output cycle by cycle against a timeline computed from the wait count. An off-by-one in wait sampling moves the ack cycle, and the bench reports that as a stray or missing ack. A wait-enable gate that is ignored stretches accesses that must stay at four states. A byte lane decoded backwards lowers the wrong column strobe on byte writes.

Requests to unmapped areas and to areas outside 2–5 are held for several cycles. A decoder that fails to qualify the area would pulse a row strobe or answer with an ack.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TP   = 3'd1,
    ST_TR   = 3'd2,
    ST_TC1  = 3'd3,
    ST_TW   = 3'd4,
    ST_TC2  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/dram_area_dec.sv
module dram_area_dec #(
  parameter int AREA_W    = 3,
  parameter int N_AREA    = 4,
  parameter int AREA_BASE = 2
) (
  input  logic [AREA_W-1:0] area,
  input  logic [N_AREA-1:0] map,
  input  logic [N_AREA-1:0] wait_en,
  output logic [N_AREA-1:0] sel,
  output logic              hit,
  output logic              wen
);
  for (genvar i = 0; i < N_AREA; i++) begin : g_area
    localparam logic [AREA_W-1:0] ID = AREA_W'(AREA_BASE + i);
    assign sel[i] = (area == ID) && map[i];
  end
  assign hit = |sel;
  assign wen = |(sel & wait_en);
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ADDR_W = 24,
  parameter int AB_W   = 13,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              col_phase,
  output logic [AB_W-1:0]   bus
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  assign row = addr[COL_W+1 +: ROW_W];
  assign col = addr[1 +: COL_W];
  assign bus = col_phase ? AB_W'(col) : AB_W'(row);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       wait_hold,
  output seq_state_t state_q,
  output seq_state_t state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_TP;
      ST_TP:   state_d = ST_TR;
      ST_TR:   state_d = ST_TC1;
      ST_TC1,
      ST_TW:   state_d = wait_hold ? ST_TW : ST_TC2;
      ST_TC2:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DW        = 16,
  parameter int AB_W      = 13,
  parameter int COL_W     = 10,
  parameter int AREA_W    = 3,
  parameter int N_AREA    = 4,
  parameter int AREA_BASE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ack,
  output logic [DW-1:0]     rd_data,
  input  logic [N_AREA-1:0] cfg_dram_map,
  input  logic [N_AREA-1:0] cfg_wait_en,
  input  logic              cfg_oe_en,
  output logic [AB_W-1:0]   dram_addr,
  output logic [N_AREA-1:0] dram_ras_n,
  output logic              dram_ucas_n,
  output logic              dram_lcas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DW-1:0]     dram_dq_o,
  output logic              dram_dq_oe,
  input  logic [DW-1:0]     dram_dq_i,
  input  logic              dram_wait
);
  localparam int ROW_W = ADDR_W - AREA_W - COL_W - 1;

  seq_state_t state_q, state_d;
  logic [N_AREA-1:0] dec_sel;
  logic              dec_hit, dec_wen, start;

  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic [N_AREA-1:0] sel_q, cur_sel;
  logic              write_q, word_q, wen_q;
  logic              cur_write, cur_word;
  logic [DW-1:0]     wdata_q;

  logic              row_on, col_on, up_en, lo_en;
  logic [AB_W-1:0]   addr_d;

  dram_area_dec #(.AREA_W(AREA_W), .N_AREA(N_AREA), .AREA_BASE(AREA_BASE)) u_dec (
    .area    (req_addr[ADDR_W-1 -: AREA_W]),
    .map     (cfg_dram_map),
    .wait_en (cfg_wait_en),
    .sel     (dec_sel),
    .hit     (dec_hit),
    .wen     (dec_wen)
  );

  assign start = (state_q == ST_IDLE) && req_valid && dec_hit;

  dram_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wait_hold (wen_q & dram_wait),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  // Request fields that apply to the state being entered.
  assign cur_addr  = start ? req_addr  : addr_q;
  assign cur_sel   = start ? dec_sel   : sel_q;
  assign cur_write = start ? req_write : write_q;
  assign cur_word  = start ? req_word  : word_q;

  assign col_on = (state_d == ST_TC1) || (state_d == ST_TW) || (state_d == ST_TC2);
  assign row_on = col_on || (state_d == ST_TR);
  assign up_en  = !(cur_write && !cur_word && cur_addr[0]);
  assign lo_en  = !(cur_write && !cur_word && !cur_addr[0]);

  dram_addr_mux #(.ADDR_W(ADDR_W), .AB_W(AB_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_mux (
    .addr      (cur_addr),
    .col_phase (col_on),
    .bus       (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      sel_q   <= '0;
      write_q <= 1'b0;
      word_q  <= 1'b0;
      wen_q   <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      sel_q   <= dec_sel;
      write_q <= req_write;
      word_q  <= req_word;
      wen_q   <= dec_wen;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_addr   <= '0;
      dram_ras_n  <= '1;
      dram_ucas_n <= 1'b1;
      dram_lcas_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_o   <= '0;
      dram_dq_oe  <= 1'b0;
      req_ack     <= 1'b0;
      rd_data     <= '0;
    end else begin
      dram_addr   <= addr_d;
      dram_ras_n  <= row_on ? ~cur_sel : '1;
      dram_ucas_n <= !(col_on && up_en);
      dram_lcas_n <= !(col_on && lo_en);
      dram_we_n   <= !(col_on && cur_write);
      dram_oe_n   <= !(col_on && !cur_write && cfg_oe_en);
      dram_dq_o   <= start ? req_wdata : wdata_q;
      dram_dq_oe  <= col_on && cur_write;
      req_ack     <= (state_q == ST_TC2);
      if (state_q == ST_TC2) rd_data <= dram_dq_i;
    end
  end
endmodule

module dram_cycle_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int N_AREA = 4
) (
  input logic              clk,
  input logic              rst,
  input seq_state_t        state,
  input logic              wen_q,
  input logic [N_AREA-1:0] ras_n,
  input logic              ucas_n,
  input logic              lcas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              ack
);
  assert_one_ras_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ras_n));

  assert_cas_in_ras_R4: assert property (@(posedge clk) disable iff (rst)
    (!ucas_n || !lcas_n) |-> (~ras_n != '0));

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_no_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TC1 && !wen_q) |=> (state == ST_TC2));

  assert_oe_we_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  assert_drive_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !we_n);

  assert_tp_first_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_TP));
endmodule

bind dram_cycle_seq dram_cycle_seq_chk #(.N_AREA(N_AREA)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .state  (state_q),
  .wen_q  (wen_q),
  .ras_n  (dram_ras_n),
  .ucas_n (dram_ucas_n),
  .lcas_n (dram_lcas_n),
  .we_n   (dram_we_n),
  .oe_n   (dram_oe_n),
  .dq_oe  (dram_dq_oe),
  .ack    (req_ack)
);

// File: tb/test_dram_cycle_seq.sv
`timescale 1ns/1ps
module test_dram_cycle_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] rd_data;
  logic [3:0]  cfg_dram_map = 4'hF, cfg_wait_en = 4'h0;
  logic        cfg_oe_en = 1'b0;
  logic [12:0] dram_addr;
  logic [3:0]  dram_ras_n;
  logic        dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_o;
  logic [15:0] dram_dq_i = '0;
  logic        dram_wait = 1'b0;

  int checks = 0, failures = 0, seed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_cycle_seq i_dram_cycle_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .rd_data(rd_data), .cfg_dram_map(cfg_dram_map),
    .cfg_wait_en(cfg_wait_en), .cfg_oe_en(cfg_oe_en), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o),
    .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i), .dram_wait(dram_wait)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // One access to an area mapped as DRAM; sz: 0 word, 1 byte even, 2 byte odd.
  task automatic run_tx(input int area, input int wr, input int sz, input int waits);
    int row, col, wd, rdv, nw, ackk, up, lo, ras_lo;
    bit wen;
    seed++;
    row = (seed * 37 + 5) & 1023;
    col = (seed * 91 + 3) & 1023;
    wd  = ((seed * 257) ^ 16'hA5C3) & 16'hFFFF;
    rdv = ((seed * 4099) ^ 16'h3C5A) & 16'hFFFF;
    wen = cfg_wait_en[area-2];
    nw  = wen ? waits : 0;
    ackk = 5 + nw;
    up = !(wr == 1 && sz == 2);
    lo = !(wr == 1 && sz == 1);
    ras_lo = 15 & ~(1 << (area - 2));
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr[0];
    req_word  = (sz == 0);
    req_addr  = 24'((area << 21) | (row << 11) | (col << 1) | (sz == 2 ? 1 : 0));
    req_wdata = wd[15:0];
    dram_dq_i = rdv[15:0];
    for (int k = 1; k <= ackk; k++) begin
      bit colph, rowph;
      @(negedge clk);
      colph = (k >= 3) && (k < ackk);
      rowph = (k >= 2) && (k < ackk);
      chk(int'(dram_ras_n), rowph ? ras_lo : 15, "R2 R4 row strobe");
      if (k < ackk) chk(int'(dram_addr), (k <= 2) ? row : col, "R3 address mux");
      chk(int'(dram_ucas_n), (colph && up) ? 0 : 1, "R4 R5 upper cas");
      chk(int'(dram_lcas_n), (colph && lo) ? 0 : 1, "R4 R5 lower cas");
      chk(int'(dram_we_n), (colph && wr == 1) ? 0 : 1, "R6 write enable");
      chk(int'(dram_dq_oe), (colph && wr == 1) ? 1 : 0, "R6 data drive");
      if (colph && wr == 1) chk(int'(dram_dq_o), wd, "R6 write data");
      chk(int'(dram_oe_n), (colph && wr == 0 && cfg_oe_en) ? 0 : 1, "R7 output enable");
      chk(int'(req_ack), (k == ackk) ? 1 : 0, "R1 R8 R9 R10 ack timing");
      if (k == ackk && wr == 0) chk(int'(rd_data), rdv, "R10 read data");
      dram_wait = (k >= 3) && (k < 3 + waits);
      if (k == ackk) req_valid = 1'b0;
    end
    dram_wait = 1'b0;
    @(negedge clk);
    chk(int'(req_ack), 0, "R10 ack single cycle");
  endtask

  task automatic ignored_tx(input int area);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_word  = 1'b1;
    req_addr  = 24'((area << 21) | 24'h1234);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(int'(dram_ras_n), 15, "R2 ignored area strobe");
      chk(int'(req_ack), 0, "R2 ignored area ack");
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(dram_ras_n), 15, "R11 reset ras");
    chk(int'({dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}), 15, "R11 reset strobes");
    chk(int'({dram_dq_oe, req_ack}), 0, "R11 reset ack/drive");
    rst = 1'b0;
    for (int area = 2; area <= 5; area++)
      for (int oe = 0; oe < 2; oe++)
        for (int we = 0; we < 2; we++)
          for (int wr = 0; wr < 2; wr++)
            for (int sz = 0; sz < 3; sz++)
              for (int w = 0; w < 3; w++) begin
                cfg_oe_en   = oe[0];
                cfg_wait_en = we[0] ? 4'hF : 4'h0;
                run_tx(area, wr, sz, w);
              end
    // partial map and per-area wait enables
    cfg_dram_map = 4'b0101;
    cfg_wait_en  = 4'b0100;
    ignored_tx(3);
    ignored_tx(5);
    ignored_tx(0);
    ignored_tx(1);
    ignored_tx(6);
    ignored_tx(7);
    run_tx(4, 1, 0, 2);
    run_tx(2, 0, 0, 2);
    run_tx(4, 0, 2, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule